// File: doc/BRIEF.md
# Burst-of-two quad-data-rate SRAM model

This block is a synthesizable, memory-side model of a static RAM with a read data port and a write data port that are separate. Every access moves a burst of two words. It runs from one double-rate clock. Its edges alternate between the K phase and the K# phase. After a synchronous reset, the first active edge is a K edge.

On a K edge the block samples both command selects and the shared address bus. The address taken there is the read address. The first write beat and its byte mask are captured on the same edge. On the following K# edge the block takes the write address together with the second write beat and its mask. The write buffer holds the first beat for that half cycle. The write is committed to the storage once the address arrives.

Reads return their burst 2.5 K cycles after the command, one beat per clock phase. A valid qualifier marks the two beat positions. Storage is split into byte lanes per beat so that block RAM with byte enables can be inferred. Addresses above the storage depth wrap.

Top module: `qdr_b2_sram`

## Requirements
- R1: The selects `rd_sel_n` and `wr_sel_n` are active low. They are sampled only on K edges, which are the first edge after reset and every second edge after that. Their levels on K# edges have no effect.
- R2: A read takes its address from `addr` on its K edge. A write takes its address from `addr` on the K# edge that follows its K edge.
- R3: Write beat 0 (`wdata`, `byte_en_n`) is captured on the write's K edge. Write beat 1 is captured on the following K# edge.
- R4: `byte_en_n` is active low, and per beat. Bit i, when 0, writes bits [9i+8:9i] of that beat. When it is 1, that byte keeps its old value.
- R5: For a read sampled on edge E, beat 0 appears on `rdata` after edge E+5 and beat 1 after edge E+6. `rdata_vld` is high after exactly those two edges.
- R6: While `rdata_vld` is low, `rdata` is all zeros.
- R7: A read returns the data of writes issued in its own K cycle or earlier. It is not affected by writes issued in later K cycles.
- R8: A read can be issued in every K cycle. Consecutive bursts leave the output without gaps.
- R9: A K cycle in which neither select is low leaves the storage unchanged, whatever the data, mask and address inputs are.
- R10: Only the low log2(DEPTH) address bits select a location, so address a and address a+DEPTH are the same location.
- R11: While `rst` is high, `rdata_vld` and `rdata` are cleared on each edge and any read in flight is dropped. Storage contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; edges alternate K and K# |
| rst | input | 1 | Synchronous active-high reset |
| rd_sel_n | input | 1 | Read select, active low, sampled on K edges |
| wr_sel_n | input | 1 | Write select, active low, sampled on K edges |
| addr | input | ADDR_W | Read address on K edges, write address on K# edges |
| byte_en_n | input | NBYTES | Active-low byte write enables for the current beat |
| wdata | input | NBYTES*BYTE_W | Write data beat |
| rdata | output | NBYTES*BYTE_W | Read data beat, zero when not valid |
| rdata_vld | output | 1 | High on the two beat positions of a returned burst |

## Verification
A table of K cycles interleaves full writes, a write that masks different bytes in each beat, and a read and a write to the same location in the same K cycle. It also places a write after a pending read and uses aliased addresses. This separates the case where beat 0 and beat 1 are swapped, the case where a mask is applied to the wrong beat, and the case where the read-versus-write ordering is wrong. Back-to-back reads show whether the pipeline drops or repeats a burst. Directed cycles then assert the selects on K# edges only, to tell apart a K-phase decoder and a decoder that ignores the phase. They also reset with a burst in flight, to show whether stale beats survive the reset.

// File: rtl/qdr_b2_pkg.sv
package qdr_b2_pkg;
  localparam int unsigned BYTE_W_DEF = 9;
  localparam int unsigned NBYTES_DEF = 4;
  localparam int unsigned ADDR_W_DEF = 18;
  localparam int unsigned DEPTH_DEF  = 256;
  localparam int unsigned BEATS      = 2;

  // clock phase of the double-rate edge about to occur
  typedef enum logic {
    PH_K  = 1'b0,
    PH_KB = 1'b1
  } phase_e;
endpackage

// File: rtl/qdr_b2_cmd.sv
module qdr_b2_cmd
  import qdr_b2_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned NBYTES = NBYTES_DEF,
  parameter int unsigned BYTE_W = BYTE_W_DEF
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                rd_sel_n,
  input  logic                                wr_sel_n,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [NBYTES-1:0]                   byte_en_n,
  input  logic [NBYTES*BYTE_W-1:0]            wdata,
  output phase_e                              phase,
  output logic                                rd_go,
  output logic                                rd_en,
  output logic [IDX_W-1:0]                    rd_idx,
  output logic                                wr_en,
  output logic [IDX_W-1:0]                    wr_idx,
  output logic [BEATS-1:0][NBYTES*BYTE_W-1:0] wd,
  output logic [BEATS-1:0][NBYTES-1:0]        wm_n
);
  localparam int unsigned WORD_W = NBYTES * BYTE_W;

  logic              wr_pend;
  logic [WORD_W-1:0] wb_data;
  logic [NBYTES-1:0] wb_mask_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_K;
      rd_go     <= 1'b0;
      wr_pend   <= 1'b0;
      rd_idx    <= '0;
      wb_data   <= '0;
      wb_mask_n <= '1;
    end else begin
      phase <= (phase == PH_K) ? PH_KB : PH_K;
      if (phase == PH_K) begin
        rd_go   <= ~rd_sel_n;
        wr_pend <= ~wr_sel_n;
        if (!rd_sel_n) rd_idx <= addr[IDX_W-1:0];
        if (!wr_sel_n) begin
          wb_data   <= wdata;
          wb_mask_n <= byte_en_n;
        end
      end
    end
  end

  // read the array one K cycle after the command, so writes of the same
  // K cycle (committed on the K# edge in between) are already visible
  assign rd_en   = rd_go && (phase == PH_K);
  assign wr_en   = wr_pend && (phase == PH_KB);
  assign wr_idx  = addr[IDX_W-1:0];
  assign wd[0]   = wb_data;
  assign wd[1]   = wdata;
  assign wm_n[0] = wb_mask_n;
  assign wm_n[1] = byte_en_n;

  generate
    if (ADDR_W > IDX_W) begin : g_wrap
      logic unused_hi_bits;
      assign unused_hi_bits = ^addr[ADDR_W-1:IDX_W];
    end
  endgenerate
endmodule

// File: rtl/qdr_b2_array.sv
module qdr_b2_array
  import qdr_b2_pkg::*;
#(
  parameter int unsigned DEPTH  = DEPTH_DEF,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned NBYTES = NBYTES_DEF,
  parameter int unsigned BYTE_W = BYTE_W_DEF
) (
  input  logic                                clk,
  input  logic                                wr_en,
  input  logic [IDX_W-1:0]                    wr_idx,
  input  logic [BEATS-1:0][NBYTES*BYTE_W-1:0] wd,
  input  logic [BEATS-1:0][NBYTES-1:0]        wm_n,
  input  logic                                rd_en,
  input  logic [IDX_W-1:0]                    rd_idx,
  output logic [BEATS-1:0][NBYTES*BYTE_W-1:0] rq
);
  // one simple-dual-port lane per beat and byte
  for (genvar bt = 0; bt < BEATS; bt++) begin : g_beat
    for (genvar by = 0; by < NBYTES; by++) begin : g_byte
      logic [BYTE_W-1:0] mem [DEPTH];
      logic [BYTE_W-1:0] q;

      always_ff @(posedge clk) begin
        if (wr_en && !wm_n[bt][by]) mem[wr_idx] <= wd[bt][by*BYTE_W +: BYTE_W];
        if (rd_en) q <= mem[rd_idx];
      end

      assign rq[bt][by*BYTE_W +: BYTE_W] = q;
    end
  end
endmodule

// File: rtl/qdr_b2_rdpipe.sv
module qdr_b2_rdpipe
  import qdr_b2_pkg::*;
#(
  parameter int unsigned WORD_W = NBYTES_DEF * BYTE_W_DEF
) (
  input  logic                         clk,
  input  logic                         rst,
  input  phase_e                       phase,
  input  logic                         rd_go,
  input  logic [BEATS-1:0][WORD_W-1:0] rq,
  output logic [WORD_W-1:0]            rdata,
  output logic                         rdata_vld
);
  logic                         vld_b;
  logic                         vld_c;
  logic [BEATS-1:0][WORD_W-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_b     <= 1'b0;
      vld_c     <= 1'b0;
      hold      <= '0;
      rdata     <= '0;
      rdata_vld <= 1'b0;
    end else if (phase == PH_K) begin
      vld_b     <= rd_go;
      vld_c     <= vld_b;
      hold      <= rq;
      rdata     <= vld_c ? hold[1] : '0;
      rdata_vld <= vld_c;
    end else begin
      rdata     <= vld_c ? hold[0] : '0;
      rdata_vld <= vld_c;
    end
  end
endmodule

// File: rtl/qdr_b2_sram.sv
module qdr_b2_sram
  import qdr_b2_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned DEPTH  = DEPTH_DEF,
  parameter int unsigned NBYTES = NBYTES_DEF,
  parameter int unsigned BYTE_W = BYTE_W_DEF
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_sel_n,
  input  logic                     wr_sel_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NBYTES-1:0]        byte_en_n,
  input  logic [NBYTES*BYTE_W-1:0] wdata,
  output logic [NBYTES*BYTE_W-1:0] rdata,
  output logic                     rdata_vld
);
  localparam int unsigned WORD_W = NBYTES * BYTE_W;
  localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  phase_e                       phase;
  logic                         rd_go;
  logic                         rd_en;
  logic [IDX_W-1:0]             rd_idx;
  logic                         wr_en;
  logic [IDX_W-1:0]             wr_idx;
  logic [BEATS-1:0][WORD_W-1:0] wd;
  logic [BEATS-1:0][NBYTES-1:0] wm_n;
  logic [BEATS-1:0][WORD_W-1:0] rq;

  qdr_b2_cmd #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)
  ) u_cmd (
    .clk(clk), .rst(rst), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .addr(addr), .byte_en_n(byte_en_n), .wdata(wdata),
    .phase(phase), .rd_go(rd_go), .rd_en(rd_en), .rd_idx(rd_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wd(wd), .wm_n(wm_n)
  );

  qdr_b2_array #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)
  ) u_array (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wd(wd), .wm_n(wm_n),
    .rd_en(rd_en), .rd_idx(rd_idx), .rq(rq)
  );

  qdr_b2_rdpipe #(
    .WORD_W(WORD_W)
  ) u_rdpipe (
    .clk(clk), .rst(rst), .phase(phase), .rd_go(rd_go), .rq(rq),
    .rdata(rdata), .rdata_vld(rdata_vld)
  );
endmodule

// File: rtl/qdr_b2_sram_chk.sv
module qdr_b2_sram_chk #(
  parameter int unsigned WORD_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_sel_n,
  input logic              k_ph,
  input logic [WORD_W-1:0] rdata,
  input logic              rdata_vld
);
  logic       ck_ph;
  logic [6:0] hist;

  // independent phase tracker and history of K-edge read commands
  always_ff @(posedge clk) begin
    if (rst) begin
      ck_ph <= 1'b0;
      hist  <= '0;
    end else begin
      ck_ph <= ~ck_ph;
      hist  <= {hist[5:0], (!ck_ph && !rd_sel_n)};
    end
  end

  a_r1_phase_align: assert property (@(posedge clk) disable iff (rst)
    k_ph == ck_ph);

  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    rdata_vld == (hist[5] || hist[6]));

  a_r6_zero_idle: assert property (@(posedge clk) disable iff (rst)
    !rdata_vld |-> rdata == '0);

  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (!rdata_vld && rdata == '0));
endmodule

bind qdr_b2_sram qdr_b2_sram_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .rd_sel_n(rd_sel_n), .k_ph(phase),
  .rdata(rdata), .rdata_vld(rdata_vld)
);

// File: tb/qdr_b2_sram_tb_top.sv
`timescale 1ns/1ps
module qdr_b2_sram_tb_top;
  localparam int AW = 18;
  localparam int DP = 256;
  localparam int N  = 13;

  typedef struct packed {
    logic          rd;
    logic [AW-1:0] ra;
    logic          wr;
    logic [AW-1:0] wa;
    logic [35:0]   d0;
    logic [35:0]   d1;
    logic [3:0]    m0;
    logic [3:0]    m1;
  } vec_t;

  // one entry per K cycle; selects active high here, inverted when driven
  localparam vec_t VT [N] = '{
    '{1'b0, 18'd0,   1'b1, 18'd5,   36'h100000A01, 36'h200000B01, 4'b0000, 4'b0000}, // R2 R3 full write
    '{1'b1, 18'd5,   1'b1, 18'd9,   36'h300000A02, 36'h400000B02, 4'b0000, 4'b0000}, // R2 read, R8
    '{1'b1, 18'd9,   1'b1, 18'd5,   36'hFFFFFFFFF, 36'hEEEEEEEEE, 4'b1110, 4'b0111}, // R4 per-beat mask
    '{1'b1, 18'd5,   1'b1, 18'd300, 36'h500000C03, 36'h600000D03, 4'b0000, 4'b0000}, // R4 merge, R10
    '{1'b1, 18'd44,  1'b1, 18'd10,  36'h700000E04, 36'h800000F04, 4'b0000, 4'b0000}, // R10 alias
    '{1'b1, 18'd10,  1'b1, 18'd10,  36'h123456789, 36'h987654321, 4'b0000, 4'b0000}, // R7 same cycle
    '{1'b1, 18'd266, 1'b0, 18'd0,   36'h0,         36'h0,         4'b0000, 4'b0000}, // R10 read alias
    '{1'b0, 18'd0,   1'b1, 18'd10,  36'h0AAAAAAAA, 36'h055555555, 4'b0000, 4'b0000}, // R7 later write
    '{1'b0, 18'd5,   1'b0, 18'd9,   36'hDEADBEEF0, 36'hCAFE0F00D, 4'b0000, 4'b0000}, // R9 no-op
    '{1'b1, 18'd10,  1'b0, 18'd0,   36'h0,         36'h0,         4'b0000, 4'b0000}, // R8 back-to-back
    '{1'b1, 18'd5,   1'b0, 18'd0,   36'h0,         36'h0,         4'b0000, 4'b0000}, // R9 check
    '{1'b1, 18'd9,   1'b0, 18'd0,   36'h0,         36'h0,         4'b0000, 4'b0000}, // R9 check
    '{1'b1, 18'd44,  1'b0, 18'd0,   36'h0,         36'h0,         4'b0000, 4'b0000}  // R10 check
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_sel_n = 1'b1;
  logic          wr_sel_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [3:0]    byte_en_n = '1;
  logic [35:0]   wdata = '0;
  logic [35:0]   rdata;
  logic          rdata_vld;

  int n_chk = 0;
  int n_bad = 0;

  logic [35:0] mdl [DP][2];
  logic        ev [N+3];
  logic [35:0] e0 [N+3];
  logic [35:0] e1 [N+3];

  always #2.5 clk = ~clk;

  qdr_b2_sram #(.ADDR_W(AW), .DEPTH(DP)) dut_i (
    .clk(clk), .rst(rst), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .addr(addr), .byte_en_n(byte_en_n), .wdata(wdata),
    .rdata(rdata), .rdata_vld(rdata_vld)
  );

  task automatic chk(input string req, input logic v_exp, input logic [35:0] d_exp);
    n_chk++;
    if (rdata_vld !== v_exp || rdata !== d_exp) begin
      n_bad++;
      $display("FAIL %s: got vld=%0b rdata=%h, expected vld=%0b rdata=%h",
               req, rdata_vld, rdata, v_exp, d_exp);
    end
  endtask

  task automatic mdl_write(input logic [AW-1:0] a, input int bt,
                           input logic [35:0] d, input logic [3:0] m);
    for (int i = 0; i < 4; i++)
      if (!m[i]) mdl[a[7:0]][bt][9*i +: 9] = d[9*i +: 9];
  endtask

  // drive the K-edge half, then wait past that edge
  task automatic half_k(input logic rd, input logic [AW-1:0] ra, input logic wr,
                        input logic [35:0] d0, input logic [3:0] m0);
    rd_sel_n = ~rd; wr_sel_n = ~wr; addr = ra; wdata = d0; byte_en_n = m0;
    @(negedge clk);
  endtask

  // drive the K#-edge half, then wait past that edge
  task automatic half_kb(input logic rs_n, input logic ws_n, input logic [AW-1:0] wa,
                         input logic [35:0] d1, input logic [3:0] m1);
    rd_sel_n = rs_n; wr_sel_n = ws_n; addr = wa; wdata = d1; byte_en_n = m1;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog: got no end, expected end of test");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset state", 1'b0, 36'h0);
    rst = 1'b0;

    // table walk: next edge is a K edge
    for (int k = 0; k < N + 3; k++) begin
      vec_t v;
      v = (k < N) ? VT[k] : '0;
      if (v.wr) begin
        mdl_write(v.wa, 0, v.d0, v.m0);
        mdl_write(v.wa, 1, v.d1, v.m1);
      end
      ev[k] = v.rd;
      e0[k] = v.rd ? mdl[v.ra[7:0]][0] : 36'h0;
      e1[k] = v.rd ? mdl[v.ra[7:0]][1] : 36'h0;
      half_k(v.rd, v.ra, v.wr, v.d0, v.m0);
      if (k >= 3) chk("R5 R7 R8 beat1", ev[k-3], e1[k-3]);
      else        chk("R6 idle after reset", 1'b0, 36'h0);
      half_kb(1'b1, 1'b1, v.wa, v.d1, v.m1);
      if (k >= 2) chk("R5 R7 R8 beat0", ev[k-2], e0[k-2]);
      else        chk("R6 idle after reset", 1'b0, 36'h0);
    end

    // R1: selects low only on a K# edge must do nothing
    half_k(1'b0, 18'd5, 1'b0, 36'h0, 4'h0);
    half_kb(1'b0, 1'b0, 18'd5, 36'hABCABCABC, 4'h0);
    for (int i = 0; i < 4; i++) begin
      half_k(1'b0, 18'd0, 1'b0, 36'h0, 4'hF);
      chk("R1 K# read ignored", 1'b0, 36'h0);
      half_kb(1'b1, 1'b1, 18'd0, 36'h0, 4'hF);
      chk("R1 K# read ignored", 1'b0, 36'h0);
    end
    half_k(1'b1, 18'd5, 1'b0, 36'h0, 4'hF);
    half_kb(1'b1, 1'b1, 18'd0, 36'h0, 4'hF);
    half_k(1'b0, 18'd0, 1'b0, 36'h0, 4'hF);
    half_kb(1'b1, 1'b1, 18'd0, 36'h0, 4'hF);
    half_k(1'b0, 18'd0, 1'b0, 36'h0, 4'hF);
    half_kb(1'b1, 1'b1, 18'd0, 36'h0, 4'hF);
    chk("R1 K# write ignored beat0", 1'b1, mdl[5][0]);
    half_k(1'b0, 18'd0, 1'b0, 36'h0, 4'hF);
    chk("R1 K# write ignored beat1", 1'b1, mdl[5][1]);
    half_kb(1'b1, 1'b1, 18'd0, 36'h0, 4'hF);
    chk("R5 exactly two beats", 1'b0, 36'h0);

    // R11: reset with a burst in flight
    half_k(1'b1, 18'd9, 1'b0, 36'h0, 4'hF);
    half_kb(1'b1, 1'b1, 18'd0, 36'h0, 4'hF);
    half_k(1'b0, 18'd0, 1'b0, 36'h0, 4'hF);
    rst = 1'b1;
    @(negedge clk);
    chk("R11 reset mid-burst", 1'b0, 36'h0);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      half_k(1'b0, 18'd0, 1'b0, 36'h0, 4'hF);
      chk("R11 no stale beat", 1'b0, 36'h0);
      half_kb(1'b1, 1'b1, 18'd0, 36'h0, 4'hF);
      chk("R11 no stale beat", 1'b0, 36'h0);
    end

    // R11: storage kept and phase realigned after reset
    half_k(1'b1, 18'd9, 1'b0, 36'h0, 4'hF);
    half_kb(1'b1, 1'b1, 18'd0, 36'h0, 4'hF);
    half_k(1'b0, 18'd0, 1'b0, 36'h0, 4'hF);
    half_kb(1'b1, 1'b1, 18'd0, 36'h0, 4'hF);
    half_k(1'b0, 18'd0, 1'b0, 36'h0, 4'hF);
    half_kb(1'b1, 1'b1, 18'd0, 36'h0, 4'hF);
    chk("R11 contents kept beat0", 1'b1, mdl[9][0]);
    half_k(1'b0, 18'd0, 1'b0, 36'h0, 4'hF);
    chk("R11 contents kept beat1", 1'b1, mdl[9][1]);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule